// File: doc/BRIEF.md
# Code-Space Mapped Page Store Controller

This block sits beside an 8-bit microcontroller core and gives it a small non-volatile byte store of three 64-byte pages. The core reaches it through four special function registers, picked by a 2-bit select: 0 is the command register on write and the status register on read, 1 is the low address, 2 is the high address and 3 is the data register. Firmware fills a 64-byte page buffer one byte at a time through the data register. It then issues a timed erase, a program or an erase-then-program of one page.

The store is never read through the registers. A map command opens a window at the top of code space, and code fetches that land in the window return stored bytes. An unmap command closes the window again. Outside the window, and while the window is closed or an operation runs, code reads return the normal code memory data unchanged.

The sequencer has three named states. IDLE accepts commands. ERASE counts down the erase time. PROG counts down the program time. The transitions are:
- START_ERASE: IDLE to ERASE, on command 01h or 03h.
- START_PROG: IDLE to PROG, on command 02h.
- CHAIN: ERASE to PROG, at the end of an erase started by 03h.
- FINISH: ERASE or PROG back to IDLE, which sets the done bit.

Top module: `eemap_ctrl`

## Requirements
- R1: After reset the status reads 00h and the store is unmapped. Every stored byte holds FFh.
- R2: Command 09h maps the store and command 0Ah unmaps it. While mapped and idle, a code read at FF00h–FFBFh returns the stored byte of page addr[7:6], byte addr[5:0]. Every other code read returns code_mem_data.
- R3: Status bit 0 is busy, bit 1 is done and bit 2 is error; bits 7:3 read 0. Each command accepted in IDLE first clears done and error.
- R4: A write to the data register (select 3) stores the byte in the page buffer at index addr_lo[5:0] and marks that index loaded.
- R5: Command 01h keeps busy high for exactly ERASE_MS×CLK_PER_MS cycles. It then sets every byte of the target page to FFh and sets done.
- R6: Command 02h keeps busy high for exactly PROG_MS×CLK_PER_MS cycles. It then replaces only the loaded bytes of the target page with buffer data, clears all loaded marks and sets done.
- R7: Command 03h performs an erase and then a program, busy for (ERASE_MS+PROG_MS)×CLK_PER_MS cycles in total. The final page holds FFh except at the loaded bytes.
- R8: An erase or program command issued while unmapped, with addr_hi not FFh, or with addr_lo[7:6] equal to 3 only sets the error bit. It leaves busy low and the store unchanged.
- R9: While busy, code reads in the window pass through, and command and data register writes are ignored.
- R10: The target page is addr_lo[7:6], captured when the command is accepted. Later address writes do not move an operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_we | input | 1 | Register write strobe |
| sfr_sel | input | 2 | Register select: 0 command/status, 1 address low, 2 address high, 3 data |
| sfr_wdata | input | 8 | Register write data |
| sfr_status | output | 8 | Status register value |
| code_addr | input | 16 | Code memory read address |
| code_mem_data | input | 8 | Data from the normal code memory |
| code_rdata | output | 8 | Code read data returned to the core |

## Verification
The bench builds the block with CLK_PER_MS set to 10. This makes erase 20 cycles, program 40 cycles and the chained operation 60 cycles. At that scale the exact busy length of every operation can be counted cycle by cycle. It also leaves room to issue register writes and window reads in the middle of an operation, and still run several full erase and program sequences on all three pages.

// File: rtl/eemap_pkg.sv
package eemap_pkg;
    localparam int PAGE_BYTES = 64;
    localparam int NUM_PAGES  = 3;

    localparam logic [7:0] CMD_ERASE = 8'h01;
    localparam logic [7:0] CMD_PROG  = 8'h02;
    localparam logic [7:0] CMD_BOTH  = 8'h03;
    localparam logic [7:0] CMD_MAP   = 8'h09;
    localparam logic [7:0] CMD_UNMAP = 8'h0A;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_ALO  = 2'd1;
    localparam logic [1:0] SEL_AHI  = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_PROG  = 2'd2
    } eemap_state_e;
endpackage

// File: rtl/eemap_page_buf.sv
module eemap_page_buf #(
    parameter int BYTES = 64,
    localparam int IW = $clog2(BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [7:0]             wr_data,
    input  logic                   clear,
    output logic [BYTES-1:0][7:0]  buf_data,
    output logic [BYTES-1:0]       loaded
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_data <= '0;
            loaded   <= '0;
        end else begin
            if (clear) loaded <= '0;
            if (wr_en) begin
                buf_data[wr_idx] <= wr_data;
                loaded[wr_idx]   <= 1'b1;
            end
        end
    end

    // R4: a write marks its index loaded
    p_load_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> loaded[$past(wr_idx)]);
    // R6: marks are gone after a program
    p_clear_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !wr_en) |=> (loaded == '0));
endmodule

// File: rtl/eemap_array.sv
module eemap_array #(
    parameter int BYTES = 64,
    parameter int PAGES = 3,
    localparam int DEPTH = BYTES * PAGES,
    localparam int IW = $clog2(BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   erase_en,
    input  logic                   prog_en,
    input  logic [1:0]             page,
    input  logic [BYTES-1:0][7:0]  buf_data,
    input  logic [BYTES-1:0]       loaded,
    input  logic                   rd_ok,
    input  logic [1:0]             rd_page,
    input  logic [IW-1:0]          rd_byte,
    input  logic [7:0]             pass_data,
    output logic [7:0]             rd_data
);
    logic [7:0] mem [DEPTH];
    logic [7:0] first_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < BYTES; i++) mem[int'(page) * BYTES + i] <= 8'hFF;
        end else if (prog_en) begin
            for (int i = 0; i < BYTES; i++)
                if (loaded[i]) mem[int'(page) * BYTES + i] <= buf_data[i];
        end
    end

    assign rd_data    = rd_ok ? mem[int'(rd_page) * BYTES + int'(rd_byte)] : pass_data;
    assign first_byte = mem[int'(page) * BYTES];

    // R5: an erase leaves the page start at FFh
    p_erase_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en && !prog_en) |=> (page != $past(page) || first_byte == 8'hFF));
    // R8: target page is always a real page
    p_page_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_en || prog_en) |-> (int'(page) < PAGES));
endmodule

// File: rtl/eemap_seq.sv
module eemap_seq
    import eemap_pkg::*;
#(
    parameter int ERASE_CYC = 80000,
    parameter int PROG_CYC  = 160000,
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int TW = $clog2(MAX_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_code,
    input  logic [7:0] addr_hi,
    input  logic [7:0] addr_lo,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic       mapped,
    output logic [1:0] op_page,
    output logic       erase_pulse,
    output logic       prog_pulse
);
    eemap_state_e state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic chain_q, chain_d, mapped_d, done_d, err_d;
    logic [1:0] page_d;
    logic bad_target;

    assign bad_target = !mapped || (addr_hi != 8'hFF) || (addr_lo[7:6] == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            chain_q <= 1'b0;
            op_page <= 2'd0;
            mapped  <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            chain_q <= chain_d;
            op_page <= page_d;
            mapped  <= mapped_d;
            done    <= done_d;
            err     <= err_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        timer_d  = timer_q;
        chain_d  = chain_q;
        page_d   = op_page;
        mapped_d = mapped;
        done_d   = done;
        err_d    = err;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr) begin
                    done_d = 1'b0;
                    err_d  = 1'b0;
                    case (cmd_code)
                        CMD_MAP:   mapped_d = 1'b1;
                        CMD_UNMAP: mapped_d = 1'b0;
                        CMD_ERASE, CMD_PROG, CMD_BOTH: begin
                            if (bad_target) begin
                                err_d = 1'b1;
                            end else begin
                                page_d  = addr_lo[7:6];
                                chain_d = (cmd_code == CMD_BOTH);
                                if (cmd_code == CMD_PROG) begin
                                    state_d = ST_PROG;   // START_PROG
                                    timer_d = TW'(PROG_CYC - 1);
                                end else begin
                                    state_d = ST_ERASE;  // START_ERASE
                                    timer_d = TW'(ERASE_CYC - 1);
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ERASE: begin
                if (timer_q == '0) begin
                    if (chain_q) begin
                        state_d = ST_PROG;               // CHAIN
                        timer_d = TW'(PROG_CYC - 1);
                        chain_d = 1'b0;
                    end else begin
                        state_d = ST_IDLE;               // FINISH
                        done_d  = 1'b1;
                    end
                end else begin
                    timer_d = timer_q - 1'b1;
                end
            end
            ST_PROG: begin
                if (timer_q == '0) begin
                    state_d = ST_IDLE;                   // FINISH
                    done_d  = 1'b1;
                end else begin
                    timer_d = timer_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        erase_pulse = (state_q == ST_ERASE) && (timer_q == '0);
        prog_pulse  = (state_q == ST_PROG) && (timer_q == '0);
    end

    // R3: done and busy never both set
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8: a rejected command never starts an operation
    p_err_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);
    // R9: the map state is frozen during an operation
    p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mapped));
    // R10: target page is fixed while busy
    p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_page));
endmodule

// File: rtl/eemap_ctrl.sv
module eemap_ctrl
    import eemap_pkg::*;
#(
    parameter int CLK_PER_MS = 40000,
    parameter int ERASE_MS   = 2,
    parameter int PROG_MS    = 4,
    localparam int ERASE_CYC = ERASE_MS * CLK_PER_MS,
    localparam int PROG_CYC  = PROG_MS * CLK_PER_MS,
    localparam int IW = $clog2(PAGE_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sfr_we,
    input  logic [1:0]  sfr_sel,
    input  logic [7:0]  sfr_wdata,
    output logic [7:0]  sfr_status,
    input  logic [15:0] code_addr,
    input  logic [7:0]  code_mem_data,
    output logic [7:0]  code_rdata
);
    logic [7:0] addr_lo_q, addr_hi_q;
    logic busy, done, err, mapped, erase_pulse, prog_pulse;
    logic [1:0] op_page;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0] loaded;
    logic in_window, rd_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lo_q <= 8'h00;
            addr_hi_q <= 8'h00;
        end else if (sfr_we) begin
            if (sfr_sel == SEL_ALO) addr_lo_q <= sfr_wdata;
            if (sfr_sel == SEL_AHI) addr_hi_q <= sfr_wdata;
        end
    end

    eemap_seq #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(sfr_we && sfr_sel == SEL_CMD), .cmd_code(sfr_wdata),
        .addr_hi(addr_hi_q), .addr_lo(addr_lo_q),
        .busy(busy), .done(done), .err(err), .mapped(mapped),
        .op_page(op_page), .erase_pulse(erase_pulse), .prog_pulse(prog_pulse)
    );

    eemap_page_buf #(.BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sfr_we && sfr_sel == SEL_DATA && !busy),
        .wr_idx(addr_lo_q[IW-1:0]), .wr_data(sfr_wdata),
        .clear(prog_pulse), .buf_data(buf_data), .loaded(loaded)
    );

    assign in_window = (code_addr[15:8] == 8'hFF) && (code_addr[7:6] != 2'd3);
    assign rd_ok     = in_window && mapped && !busy;

    eemap_array #(.BYTES(PAGE_BYTES), .PAGES(NUM_PAGES)) u_array (
        .clk(clk), .rst_n(rst_n),
        .erase_en(erase_pulse), .prog_en(prog_pulse), .page(op_page),
        .buf_data(buf_data), .loaded(loaded),
        .rd_ok(rd_ok), .rd_page(code_addr[7:6]), .rd_byte(code_addr[IW-1:0]),
        .pass_data(code_mem_data), .rd_data(code_rdata)
    );

    assign sfr_status = {5'b0, err, done, busy};

    // R9: no stored byte reaches the core during an operation
    p_busy_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_status[0] |-> (code_rdata == code_mem_data));
    // R2: reads outside the window always pass through
    p_outside_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (code_addr[15:8] != 8'hFF) |-> (code_rdata == code_mem_data));
endmodule

// File: tb/eemap_ctrl_bench.sv
module eemap_ctrl_bench;
    localparam logic [7:0] PASS = 8'h3C;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sfr_we = 1'b0;
    logic [1:0] sfr_sel = 2'd0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_status;
    logic [15:0] code_addr = 16'h0000;
    logic [7:0] code_mem_data = PASS;
    logic [7:0] code_rdata;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    eemap_ctrl #(.CLK_PER_MS(10)) u_eemap_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_sel(sfr_sel),
        .sfr_wdata(sfr_wdata), .sfr_status(sfr_status), .code_addr(code_addr),
        .code_mem_data(code_mem_data), .code_rdata(code_rdata)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_sel = sel; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic rd(string req, logic [15:0] a, logic [7:0] exp);
        code_addr = a;
        #1;
        check(req, code_rdata, exp);
    endtask

    task automatic load(logic [7:0] alo, logic [7:0] d);
        wr(2'd1, alo);
        wr(2'd3, d);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (sfr_status[0]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 status", sfr_status, 8'h00);
        rd("R1 unmapped pass", 16'hFF00, PASS);
    endtask

    task automatic t_map();
        wr(2'd0, 8'h09);
        check("R3 status after map", sfr_status, 8'h00);
        rd("R1 erased byte", 16'hFF00, 8'hFF);
        rd("R2 page2 end", 16'hFFBF, 8'hFF);
        rd("R2 above window", 16'hFFC0, PASS);
        rd("R2 below window", 16'hFEFF, PASS);
        wr(2'd0, 8'h0A);
        rd("R2 unmapped", 16'hFF40, PASS);
        wr(2'd0, 8'h09);
    endtask

    task automatic t_errors();
        wr(2'd0, 8'h0A);
        wr(2'd2, 8'hFF);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        check("R8 unmapped erase", sfr_status, 8'h04);
        wr(2'd0, 8'h09);
        check("R3 clear on command", sfr_status, 8'h00);
        wr(2'd1, 8'hC0);
        wr(2'd0, 8'h03);
        check("R8 page 3", sfr_status, 8'h04);
        wr(2'd2, 8'hFE);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h02);
        check("R8 bad high addr", sfr_status, 8'h04);
        rd("R8 store unchanged", 16'hFF00, 8'hFF);
        wr(2'd2, 8'hFF);
    endtask

    task automatic t_program();
        int n;
        load(8'h80, 8'h11);
        load(8'h87, 8'h22);
        load(8'hBF, 8'h33);
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h02);
        busy_len(n);
        check("R6 program length", n, 40);
        check("R6 done", sfr_status, 8'h02);
        rd("R4 byte0", 16'hFF80, 8'h11);
        rd("R4 byte7", 16'hFF87, 8'h22);
        rd("R6 byte63", 16'hFFBF, 8'h33);
        rd("R6 unloaded kept", 16'hFF81, 8'hFF);
        rd("R10 other page", 16'hFF40, 8'hFF);
        load(8'h81, 8'h44);
        wr(2'd0, 8'h02);
        busy_len(n);
        rd("R6 new byte", 16'hFF81, 8'h44);
        rd("R6 marks cleared", 16'hFF80, 8'h11);
    endtask

    task automatic t_erase();
        int n;
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h01);
        busy_len(n);
        check("R5 erase length", n, 20);
        check("R5 done", sfr_status, 8'h02);
        rd("R5 erased start", 16'hFF80, 8'hFF);
        rd("R5 erased end", 16'hFFBF, 8'hFF);
    endtask

    task automatic t_combined();
        int n;
        load(8'h09, 8'h12);
        wr(2'd0, 8'h02);
        busy_len(n);
        rd("R7 preset", 16'hFF09, 8'h12);
        load(8'h03, 8'h5A);
        wr(2'd0, 8'h03);
        busy_len(n);
        check("R7 combined length", n, 60);
        rd("R7 erased old", 16'hFF09, 8'hFF);
        rd("R7 programmed", 16'hFF03, 8'h5A);
    endtask

    task automatic t_busy();
        int n;
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h01);
        rd("R9 pass while busy", 16'hFF40, PASS);
        wr(2'd1, 8'h05);
        wr(2'd3, 8'h77);
        wr(2'd0, 8'h0A);
        busy_len(n);
        check("R9 command ignored", sfr_status, 8'h02);
        rd("R9 still mapped", 16'hFF40, 8'hFF);
        rd("R10 page0 untouched", 16'hFF03, 8'h5A);
        wr(2'd0, 8'h02);
        busy_len(n);
        rd("R9 data ignored", 16'hFF05, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_errors();
        t_program();
        t_erase();
        t_combined();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule